// File: doc/BRIEF.md
# Maskable Interrupt Mode Controller

This block holds the maskable interrupt state of a small CPU core. It keeps two interrupt enable flags and a service mode, and it tracks the halted state. The instruction decoder drives it with single-cycle strobes for enable, disable, the three mode selections and halt. The sequencer sends a pulse at every instruction boundary. An interrupt request is taken only at such a boundary, and only when the primary enable flag is set.

When a request is taken, the block raises a one-cycle accept pulse and latches a service action and address for the sequencer. There are three actions:
- Mode 0: execute the opcode byte found on the data bus.
- Mode 1: restart at a fixed vector.
- Mode 2: make an indirect call through a pointer. The pointer is formed from the page register (high byte) and the data-bus byte (low byte). The block also supplies the address of the pointer's high byte, because the pointer is fetched low byte first.

An enable instruction arms the flags at once. It holds off acceptance until one more instruction has completed.

Top module: `irq_mode_ctrl`

## Requirements
- R1: After reset `en_pri_o` = 0, `en_sec_o` = 0, `mode_o` = 0, `halted_o` = 0, `take_o` = 0, `svc_act_o` = 2'b00 and `svc_addr_o` = 0.
- R2: `dis_stb` clears both enable flags at the next clock edge. This also holds when `en_stb` is high in the same cycle.
- R3: `en_stb` without `dis_stb` sets both enable flags at the next clock edge.
- R4: The first `step_done` pulse at or after an `en_stb` ends the enable instruction, and no request is taken on it. The `step_done` pulse after that one may take a request.
- R5: A request is taken only in a cycle where all of these hold: `step_done` is 1, `irq_req` is 1, the primary enable flag is 1, the enable hold-off of R4 is not active, and neither `en_stb` nor `dis_stb` is high. When a request is taken, `take_o` is 1 for exactly one cycle after that edge. `irq_req` has no effect in cycles without `step_done`.
- R6: Taking a request clears both enable flags and `halted_o` at the same edge that raises `take_o`.
- R7: The strobes `im0_stb`, `im1_stb` and `im2_stb` set `mode_o` to 0, 1 and 2. When more than one is high, the highest mode number wins. Without a strobe the mode holds.
- R8: In mode 0 a take latches `svc_act_o` = 2'b01 and `svc_addr_o` = {8'h00, bus byte}.
- R9: In mode 1 a take latches `svc_act_o` = 2'b10 and `svc_addr_o` = 16'h0038.
- R10: In mode 2 a take latches `svc_act_o` = 2'b11, `svc_addr_o` = {page, bus byte} and `svc_addr_hi_o` = `svc_addr_o` + 1, modulo 2^16.
- R11: `halt_stb` sets `halted_o`, and it stays set until a request is taken. A take in the same cycle as `halt_stb` wins. While the enables are clear, requests at boundaries leave it halted.
- R12: The service outputs keep their values between takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_stb | input | 1 | Enable-interrupts strobe |
| dis_stb | input | 1 | Disable-interrupts strobe |
| im0_stb | input | 1 | Select mode 0 |
| im1_stb | input | 1 | Select mode 1 |
| im2_stb | input | 1 | Select mode 2 |
| halt_stb | input | 1 | Enter halted state |
| step_done | input | 1 | Instruction boundary pulse |
| irq_req | input | 1 | Maskable interrupt request level |
| page_i | input | 8 | Interrupt page register |
| bus_i | input | 8 | Data-bus byte during acknowledge |
| take_o | output | 1 | One-cycle accept pulse |
| svc_act_o | output | 2 | Service action: 01 bus opcode, 10 restart, 11 vectored |
| svc_addr_o | output | 16 | Service address, opcode or pointer |
| svc_addr_hi_o | output | 16 | Address of pointer high byte |
| halted_o | output | 1 | Halted indication |
| en_pri_o | output | 1 | Primary enable flag |
| en_sec_o | output | 1 | Secondary enable flag |
| mode_o | output | 2 | Current interrupt mode |

## Verification
The bench targets several corner cases, and each one shows a specific fault:
- **Enable hold-off.** The bench raises a request on the boundary that closes an enable instruction, both when the flags were already set and when the enable coincides with the boundary. A design that takes at once produces an unexpected take.
- **Strobe collisions.** It drives enable and disable together, and several mode strobes together. A wrong priority shows up as set flags or the wrong mode.
- **Pointer wrap.** A mode-2 pointer at page FF with bus byte FF has its high-byte address at 0000. A carry or width error leaves a wrong value there.
- **Halt release.** The bench checks that halt is left only by a take, never by a masked request.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  typedef enum logic [1:0] {
    SVC_NONE    = 2'b00,
    SVC_BUS_OP  = 2'b01,
    SVC_RESTART = 2'b10,
    SVC_VECTOR  = 2'b11
  } svc_t;

  localparam logic [1:0] MODE_BUS = 2'd0;
  localparam logic [1:0] MODE_RST = 2'd1;
  localparam logic [1:0] MODE_VEC = 2'd2;

  // Next mode from the three select strobes; highest mode wins.
  function automatic logic [1:0] next_mode(input logic [1:0] cur,
                                           input logic s0, input logic s1,
                                           input logic s2);
    logic [1:0] m;
    m = cur;
    if (s0) m = MODE_BUS;
    if (s1) m = MODE_RST;
    if (s2) m = MODE_VEC;
    return m;
  endfunction

  function automatic svc_t action_of(input logic [1:0] mode);
    case (mode)
      MODE_BUS: return SVC_BUS_OP;
      MODE_RST: return SVC_RESTART;
      default:  return SVC_VECTOR;
    endcase
  endfunction

endpackage

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_stb,
  input  logic dis_stb,
  input  logic step_done,
  input  logic irq_req,
  output logic en_pri,
  output logic en_sec,
  output logic hold_off,
  output logic accept
);

  logic pri_q, sec_q, hold_q;

  // A request is taken only at a boundary, with the primary flag set, and
  // never on the boundary that closes an enable or disable instruction.
  assign accept = step_done & irq_req & pri_q & ~hold_q & ~en_stb & ~dis_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_q  <= 1'b0;
      sec_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (dis_stb || accept) begin
        pri_q <= 1'b0;
        sec_q <= 1'b0;
      end else if (en_stb) begin
        pri_q <= 1'b1;
        sec_q <= 1'b1;
      end
      if (step_done)   hold_q <= 1'b0;
      else if (en_stb) hold_q <= 1'b1;
    end
  end

  assign en_pri   = pri_q;
  assign en_sec   = sec_q;
  assign hold_off = hold_q;

endmodule

// File: rtl/irq_state_reg.sv
module irq_state_reg
  import irq_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       im0_stb,
  input  logic       im1_stb,
  input  logic       im2_stb,
  input  logic       halt_stb,
  input  logic       accept,
  output logic [1:0] mode,
  output logic       halted
);

  logic [1:0] mode_q;
  logic       halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_BUS;
      halt_q <= 1'b0;
    end else begin
      mode_q <= next_mode(mode_q, im0_stb, im1_stb, im2_stb);
      if (accept)        halt_q <= 1'b0;
      else if (halt_stb) halt_q <= 1'b1;
    end
  end

  assign mode   = mode_q;
  assign halted = halt_q;

endmodule

// File: rtl/irq_svc_unit.sv
module irq_svc_unit
  import irq_ctl_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned ADDR_W = 2 * PAGE_W,
  parameter logic [ADDR_W-1:0] RST_VEC = 'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        mode,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] bus,
  output logic              take,
  output logic [1:0]        act,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_hi
);

  localparam int unsigned PAD_W = ADDR_W - PAGE_W;

  function automatic logic [ADDR_W-1:0] svc_address(input logic [1:0] m,
                                                    input logic [PAGE_W-1:0] pg,
                                                    input logic [PAGE_W-1:0] b);
    case (m)
      MODE_BUS: return {{PAD_W{1'b0}}, b};
      MODE_RST: return RST_VEC;
      default:  return {pg[PAD_W-1:0], b};
    endcase
  endfunction

  logic [ADDR_W-1:0] addr_d;
  assign addr_d = svc_address(mode, page, bus);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take    <= 1'b0;
      act     <= SVC_NONE;
      addr    <= '0;
      addr_hi <= '0;
    end else begin
      take <= accept;
      if (accept) begin
        act     <= action_of(mode);
        addr    <= addr_d;
        addr_hi <= addr_d + 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned ADDR_W = 2 * PAGE_W,
  parameter logic [ADDR_W-1:0] RST_VEC = 'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_stb,
  input  logic              dis_stb,
  input  logic              im0_stb,
  input  logic              im1_stb,
  input  logic              im2_stb,
  input  logic              halt_stb,
  input  logic              step_done,
  input  logic              irq_req,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PAGE_W-1:0] bus_i,
  output logic              take_o,
  output logic [1:0]        svc_act_o,
  output logic [ADDR_W-1:0] svc_addr_o,
  output logic [ADDR_W-1:0] svc_addr_hi_o,
  output logic              halted_o,
  output logic              en_pri_o,
  output logic              en_sec_o,
  output logic [1:0]        mode_o
);

  logic       accept_w;
  logic       hold_off_w;
  logic [1:0] mode_w;

  irq_enable_ctl u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_stb    (en_stb),
    .dis_stb   (dis_stb),
    .step_done (step_done),
    .irq_req   (irq_req),
    .en_pri    (en_pri_o),
    .en_sec    (en_sec_o),
    .hold_off  (hold_off_w),
    .accept    (accept_w)
  );

  irq_state_reg u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .im0_stb  (im0_stb),
    .im1_stb  (im1_stb),
    .im2_stb  (im2_stb),
    .halt_stb (halt_stb),
    .accept   (accept_w),
    .mode     (mode_w),
    .halted   (halted_o)
  );

  irq_svc_unit #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .RST_VEC(RST_VEC)) u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept_w),
    .mode    (mode_w),
    .page    (page_i),
    .bus     (bus_i),
    .take    (take_o),
    .act     (svc_act_o),
    .addr    (svc_addr_o),
    .addr_hi (svc_addr_hi_o)
  );

  assign mode_o = mode_w;

endmodule

// File: rtl/irq_mode_ctrl_chk.sv
module irq_mode_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RST_VEC = 'h38
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_stb,
  input logic              dis_stb,
  input logic              step_done,
  input logic              irq_req,
  input logic              take_o,
  input logic [1:0]        svc_act_o,
  input logic [ADDR_W-1:0] svc_addr_o,
  input logic [ADDR_W-1:0] svc_addr_hi_o,
  input logic              halted_o,
  input logic              en_pri_o,
  input logic              en_sec_o,
  input logic              accept_w,
  input logic              hold_off_w
);

  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dis_stb |=> (!en_pri_o && !en_sec_o));

  a_r3_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_stb && !dis_stb) |=> (en_pri_o && en_sec_o));

  a_r4_no_take_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    en_stb |=> !take_o);

  a_r4_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off_w |-> !accept_w);

  a_r5_take_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_o) |-> $past(step_done && irq_req && en_pri_o));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  a_r6_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (!en_pri_o && !en_sec_o && !halted_o));

  a_r9_restart_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && svc_act_o == 2'b10) |-> (svc_addr_o == RST_VEC));

  a_r10_hi_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && svc_act_o == 2'b11) |-> (svc_addr_hi_o == svc_addr_o + 1'b1));

  a_r11_halt_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted_o) |-> take_o);

  a_r12_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> (take_o || ($stable(svc_act_o) && $stable(svc_addr_o))));

endmodule

bind irq_mode_ctrl irq_mode_ctrl_chk #(.ADDR_W(ADDR_W), .RST_VEC(RST_VEC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_stb        (en_stb),
  .dis_stb       (dis_stb),
  .step_done     (step_done),
  .irq_req       (irq_req),
  .take_o        (take_o),
  .svc_act_o     (svc_act_o),
  .svc_addr_o    (svc_addr_o),
  .svc_addr_hi_o (svc_addr_hi_o),
  .halted_o      (halted_o),
  .en_pri_o      (en_pri_o),
  .en_sec_o      (en_sec_o),
  .accept_w      (accept_w),
  .hold_off_w    (hold_off_w)
);

// File: tb/test_irq_mode_ctrl.sv
module test_irq_mode_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_stb = 0, dis_stb = 0, im0_stb = 0, im1_stb = 0, im2_stb = 0;
  logic halt_stb = 0, step_done = 0, irq_req = 0;
  logic [7:0] page_i = 8'h00, bus_i = 8'h00;
  logic take_o, halted_o, en_pri_o, en_sec_o;
  logic [1:0] svc_act_o, mode_o;
  logic [15:0] svc_addr_o, svc_addr_hi_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  act;
    logic [15:0] addr;
    logic [15:0] hi;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  irq_mode_ctrl i_irq_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .en_stb(en_stb), .dis_stb(dis_stb),
    .im0_stb(im0_stb), .im1_stb(im1_stb), .im2_stb(im2_stb),
    .halt_stb(halt_stb), .step_done(step_done), .irq_req(irq_req),
    .page_i(page_i), .bus_i(bus_i), .take_o(take_o), .svc_act_o(svc_act_o),
    .svc_addr_o(svc_addr_o), .svc_addr_hi_o(svc_addr_hi_o),
    .halted_o(halted_o), .en_pri_o(en_pri_o), .en_sec_o(en_sec_o),
    .mode_o(mode_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected service item from the mode rules, written independently.
  function automatic exp_t model(input int m, input logic [7:0] pg,
                                 input logic [7:0] b);
    exp_t e;
    if (m == 0)      begin e.act = 2'b01; e.addr = 16'h0000 | b; end
    else if (m == 1) begin e.act = 2'b10; e.addr = 16'd56; end
    else             begin e.act = 2'b11; e.addr = pg * 256 + b; end
    e.hi = 16'((32'(e.addr) + 1) % 65536);
    return e;
  endfunction

  // Monitor: scoreboard compare on each take pulse.
  int takes_seen = 0;
  always @(negedge clk) begin
    if (rst_n && take_o) begin
      takes_seen++;
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected take", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(svc_act_o == e.act, "R8/R9/R10 action", svc_act_o, e.act);
        check(svc_addr_o == e.addr, "R8/R9/R10 address", svc_addr_o, e.addr);
        if (e.act == 2'b11)
          check(svc_addr_hi_o == e.hi, "R10 high byte address", svc_addr_hi_o, e.hi);
        check(!en_pri_o && !en_sec_o && !halted_o, "R6 take clears state",
              {en_pri_o, en_sec_o, halted_o}, 0);
      end
    end
  end

  // Driver: one cycle of strobes, returns at the following negedge.
  task automatic cyc(input bit en = 0, input bit dis = 0, input bit done_p = 0,
                     input bit req = 0, input bit halt = 0,
                     input bit m0 = 0, input bit m1 = 0, input bit m2 = 0);
    en_stb = en; dis_stb = dis; step_done = done_p; irq_req = req;
    halt_stb = halt; im0_stb = m0; im1_stb = m1; im2_stb = m2;
    @(negedge clk);
    en_stb = 0; dis_stb = 0; step_done = 0; irq_req = 0;
    halt_stb = 0; im0_stb = 0; im1_stb = 0; im2_stb = 0;
  endtask

  task automatic expect_take(input int m);
    exp_q.push_back(model(m, page_i, bus_i));
  endtask

  initial begin
    #200000;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(!en_pri_o && !en_sec_o && mode_o == 0 && !halted_o && !take_o &&
          svc_act_o == 0 && svc_addr_o == 0, "R1 reset state",
          {en_pri_o, en_sec_o, mode_o, halted_o, take_o, svc_act_o}, 0);

    // R7 mode 1; R3 enable; R4 hold-off at closing boundary
    cyc(.m1(1));
    check(mode_o == 1, "R7 mode 1", mode_o, 1);
    cyc(.en(1));
    check(en_pri_o && en_sec_o, "R3 enable sets", {en_pri_o, en_sec_o}, 3);
    cyc(.done_p(1), .req(1));
    check(!take_o, "R4 no take at enable boundary", take_o, 0);
    // R9 restart take
    expect_take(1);
    cyc(.done_p(1), .req(1));
    check(take_o, "R5 take pulse", take_o, 1);
    cyc();
    check(!take_o, "R5 single cycle", take_o, 0);

    // R5 masked request ignored
    cyc(.done_p(1), .req(1));
    check(!take_o && !en_pri_o, "R5 masked request", take_o, 0);

    // R2 disable wins over enable, and disable after enable
    cyc(.en(1), .dis(1));
    check(!en_pri_o && !en_sec_o, "R2 disable wins", {en_pri_o, en_sec_o}, 0);
    cyc(.en(1), .done_p(1));
    cyc(.dis(1));
    check(!en_pri_o && !en_sec_o, "R2 disable clears", {en_pri_o, en_sec_o}, 0);

    // R7 priority mode 2 over mode 0; then hold
    cyc(.m0(1), .m2(1));
    check(mode_o == 2, "R7 priority", mode_o, 2);
    cyc();
    check(mode_o == 2, "R7 mode holds", mode_o, 2);

    // R10 vectored take; enable coinciding with its own boundary
    page_i = 8'h12; bus_i = 8'h34;
    cyc(.en(1), .done_p(1), .req(1));
    check(!take_o, "R4 enable at its boundary", take_o, 0);
    expect_take(2);
    cyc(.done_p(1), .req(1));
    // R12 outputs hold after take
    page_i = 8'h77; bus_i = 8'h88;
    repeat (3) cyc();
    check(svc_addr_o == 16'h1234 && svc_act_o == 2'b11, "R12 outputs hold",
          svc_addr_o, 16'h1234);

    // R10 pointer wrap
    page_i = 8'hFF; bus_i = 8'hFF;
    cyc(.en(1), .done_p(1));
    expect_take(2);
    cyc(.done_p(1), .req(1));

    // R4 enable while already enabled
    cyc(.en(1), .done_p(1));
    cyc(.en(1), .done_p(1), .req(1));
    check(!take_o && en_pri_o, "R4 re-enable blocks", take_o, 0);

    // R12 request without boundary ignored (R5)
    repeat (4) cyc(.req(1));
    check(!take_o && en_pri_o, "R5 no boundary no take", take_o, 0);

    // R8 mode 0 with halt release (R11)
    cyc(.m0(1));
    bus_i = 8'hC7;
    cyc(.halt(1));
    check(halted_o, "R11 halt sets", halted_o, 1);
    cyc(.done_p(1));
    check(halted_o, "R11 halt held", halted_o, 1);
    expect_take(0);
    cyc(.done_p(1), .req(1));
    check(!halted_o, "R11 take releases", halted_o, 0);

    // R11 masked request keeps halted
    cyc(.halt(1));
    repeat (3) cyc(.done_p(1), .req(1));
    check(halted_o && !take_o, "R11 masked stays halted", halted_o, 1);
    // R11 take wins over halt strobe in same cycle
    cyc(.en(1), .done_p(1));
    expect_take(0);
    cyc(.done_p(1), .req(1), .halt(1));
    check(!halted_o, "R11 take beats halt", halted_o, 0);

    repeat (3) cyc();
    check(exp_q.size() == 0, "R5 all expected takes seen", exp_q.size(), 0);
    check(takes_seen == 5, "R5 take count", takes_seen, 5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule